// File: doc/BRIEF.md
# Indexed Mailbox with Per-Slot Semaphores

This block carries data items from a producing processor to a consuming processor through a small shared memory. The memory is split into fixed slots, and each slot carries its own semaphore (a full flag). The producer fills a slot word by word. Writing the slot's final word raises that slot's flag. Several slots may be full at once. The consumer reads any slot, in any order, through a separate read port. It then acknowledges the slot, which clears the flag and frees the slot for reuse.

An interrupt line tells the consumer that work is waiting. The line stays high while any flag is set that a per-slot mask does not suppress. A mode input selects a strict single-outstanding handshake instead. In that mode the producer is refused while any slot at all is still unacknowledged. This lets the two transfer disciplines be compared on the same hardware.

Top module: `mbx_mailbox`

## Requirements
- R1: After a synchronous reset, `full_flags` is all zero, `irq` is low, `wr_err` is low and the interrupt mask is all zero (unmasked).
- R2: An accepted write stores `wr_data` at word `wr_word` of slot `wr_slot`. `rd_data` shows the word addressed by `rd_slot`/`rd_word` combinationally, from the cycle after the write edge onward.
- R3: An accepted write to word index NWORD-1 (15 by default) sets bit `wr_slot` of `full_flags` on that clock edge. Bit i of `full_flags` belongs to slot i.
- R4: In either mode, a write to a slot whose flag is set is rejected. The slot contents stay unchanged, and `wr_err` is high for exactly the cycle after the rejected write.
- R5: With `strict_mode`=0, several slots can be full at the same time. They can be read and acknowledged in an order different from the fill order.
- R6: `ack_en` with `ack_slot`=i clears flag i on that edge. An acknowledge of a slot whose flag is already clear changes nothing.
- R7: If a flag-setting write and an acknowledge hit the same slot on the same edge, the flag ends up set.
- R8: `irq` is high exactly when some slot i has its flag set and mask bit i is 0. `mask_wr_en` loads `mask_wr_data` into the mask on the edge, and a mask bit of 1 suppresses its slot.
- R9: With `strict_mode`=1, every write is rejected (see R4) while any flag is set. Writes are accepted again once all flags are clear.
- R10: `wr_err` is low in every cycle that does not follow a rejected write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strict_mode | input | 1 | 1 = single-outstanding handshake, 0 = indexed slots |
| wr_en | input | 1 | Producer write strobe |
| wr_slot | input | $clog2(NSLOT) | Producer slot index |
| wr_word | input | $clog2(NWORD) | Word index within the slot |
| wr_data | input | DW | Write data |
| wr_err | output | 1 | Previous-cycle write was rejected |
| rd_slot | input | $clog2(NSLOT) | Consumer slot index |
| rd_word | input | $clog2(NWORD) | Consumer word index |
| rd_data | output | DW | Addressed word |
| ack_en | input | 1 | Consumer acknowledge strobe |
| ack_slot | input | $clog2(NSLOT) | Slot being acknowledged |
| mask_wr_en | input | 1 | Load interrupt mask |
| mask_wr_data | input | NSLOT | New mask, 1 = suppress |
| full_flags | output | NSLOT | Per-slot semaphore status |
| irq | output | 1 | Level interrupt to consumer |

## Verification
The bench builds the block with its defaults: 8 slots of 16 words of 32 bits. With these values every slot index and the last-word boundary at index 15 are reachable in a few hundred cycles. The fill order 2, 5, 0, 7 and the service order 7, 0, 2, 5 show that reads and acknowledges need not follow the write order. The same parameters also allow the set-against-acknowledge collision, masking of a subset of full slots, and a strict-mode run in which the second slot is refused until the first is released.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int unsigned MBX_NSLOT = 8;
    localparam int unsigned MBX_NWORD = 16;
    localparam int unsigned MBX_DW    = 32;

    typedef enum logic {
        XFER_INDEXED = 1'b0,
        XFER_STRICT  = 1'b1
    } xfer_mode_e;

    function automatic logic [MBX_NSLOT-1:0] slot_onehot(input int unsigned idx, input logic en);
        logic [MBX_NSLOT-1:0] v;
        v = '0;
        if (en) v[idx] = 1'b1;
        return v;
    endfunction
endpackage

// File: rtl/mbx_store.sv
module mbx_store #(
    parameter int unsigned DEPTH = 128,
    parameter int unsigned DW    = 32,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/mbx_flags.sv
module mbx_flags #(
    parameter int unsigned NSLOT = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NSLOT-1:0] set_vec,
    input  logic [NSLOT-1:0] clr_vec,
    output logic [NSLOT-1:0] flags
);
    for (genvar gi = 0; gi < NSLOT; gi++) begin : g_sem
        always_ff @(posedge clk) begin
            if (rst)              flags[gi] <= 1'b0;
            else if (set_vec[gi]) flags[gi] <= 1'b1;
            else if (clr_vec[gi]) flags[gi] <= 1'b0;
        end

        AST_SET_RAISES: assert property (@(posedge clk) disable iff (rst)
            set_vec[gi] |=> flags[gi]); // R3
        AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
            (set_vec[gi] && clr_vec[gi]) |=> flags[gi]); // R7
        AST_FALL_NEEDS_ACK: assert property (@(posedge clk) disable iff (rst)
            $fell(flags[gi]) |-> $past(clr_vec[gi])); // R6
    end
endmodule

// File: rtl/mbx_irq_gate.sv
module mbx_irq_gate #(
    parameter int unsigned NSLOT = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NSLOT-1:0] flags,
    input  logic             mask_wr_en,
    input  logic [NSLOT-1:0] mask_wr_data,
    output logic             irq
);
    logic [NSLOT-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (rst)             mask_q <= '0;
        else if (mask_wr_en) mask_q <= mask_wr_data;
    end

    assign irq = |(flags & ~mask_q);

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
        irq |-> (flags != '0)); // R8
endmodule

// File: rtl/mbx_mailbox.sv
module mbx_mailbox
    import mbx_pkg::*;
#(
    parameter int unsigned NSLOT = MBX_NSLOT,
    parameter int unsigned NWORD = MBX_NWORD,
    parameter int unsigned DW    = MBX_DW,
    localparam int unsigned SW   = $clog2(NSLOT),
    localparam int unsigned WW   = $clog2(NWORD),
    localparam int unsigned AW   = SW + WW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             strict_mode,
    input  logic             wr_en,
    input  logic [SW-1:0]    wr_slot,
    input  logic [WW-1:0]    wr_word,
    input  logic [DW-1:0]    wr_data,
    output logic             wr_err,
    input  logic [SW-1:0]    rd_slot,
    input  logic [WW-1:0]    rd_word,
    output logic [DW-1:0]    rd_data,
    input  logic             ack_en,
    input  logic [SW-1:0]    ack_slot,
    input  logic             mask_wr_en,
    input  logic [NSLOT-1:0] mask_wr_data,
    output logic [NSLOT-1:0] full_flags,
    output logic             irq
);
    xfer_mode_e       mode;
    logic             blocked;
    logic             accept;
    logic             last_word;
    logic [NSLOT-1:0] set_vec;
    logic [NSLOT-1:0] clr_vec;

    assign mode      = xfer_mode_e'(strict_mode);
    assign blocked   = (mode == XFER_STRICT) ? (|full_flags) : full_flags[wr_slot];
    assign accept    = wr_en && !blocked;
    assign last_word = (wr_word == WW'(NWORD - 1));

    always_comb begin
        set_vec = '0;
        clr_vec = '0;
        if (accept && last_word) set_vec[wr_slot] = 1'b1;
        if (ack_en)              clr_vec[ack_slot] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) wr_err <= 1'b0;
        else     wr_err <= wr_en && blocked;
    end

    mbx_store #(.DEPTH(NSLOT * NWORD), .DW(DW)) u_store (
        .clk   (clk),
        .we    (accept),
        .waddr ({wr_slot, wr_word}),
        .wdata (wr_data),
        .raddr ({rd_slot, rd_word}),
        .rdata (rd_data)
    );

    mbx_flags #(.NSLOT(NSLOT)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .flags   (full_flags)
    );

    mbx_irq_gate #(.NSLOT(NSLOT)) u_irq (
        .clk          (clk),
        .rst          (rst),
        .flags        (full_flags),
        .mask_wr_en   (mask_wr_en),
        .mask_wr_data (mask_wr_data),
        .irq          (irq)
    );

    AST_REJECT_FULL_SLOT: assert property (@(posedge clk) disable iff (rst)
        (wr_en && full_flags[wr_slot]) |=> wr_err); // R4
    AST_STRICT_REFUSE: assert property (@(posedge clk) disable iff (rst)
        (strict_mode && wr_en && (full_flags != '0)) |=> wr_err); // R9
    AST_ERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        wr_err |-> $past(wr_en)); // R10
endmodule

// File: tb/sim_mbx_mailbox.sv
module sim_mbx_mailbox;
    logic        clk = 1'b0;
    logic        rst;
    logic        strict_mode;
    logic        wr_en;
    logic [2:0]  wr_slot;
    logic [3:0]  wr_word;
    logic [31:0] wr_data;
    logic        wr_err;
    logic [2:0]  rd_slot;
    logic [3:0]  rd_word;
    logic [31:0] rd_data;
    logic        ack_en;
    logic [2:0]  ack_slot;
    logic        mask_wr_en;
    logic [7:0]  mask_wr_data;
    logic [7:0]  full_flags;
    logic        irq;

    always #10 clk = ~clk;

    mbx_mailbox u0 (.*);

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string cur_req = "R1";

    logic [31:0] mmem [128];
    bit          mvalid [128];
    logic [7:0]  mflags = '0;
    logic [7:0]  mmask = '0;
    logic        merr = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        wr_en = 0; wr_slot = 0; wr_word = 0; wr_data = 0;
        ack_en = 0; ack_slot = 0; mask_wr_en = 0; mask_wr_data = 0;
    endtask

    // one clock: update model at the edge, compare at the following negedge
    task automatic tick();
        bit blk;
        int a;
        logic [7:0] setv, clrv;
        @(posedge clk);
        blk  = strict_mode ? (mflags != 0) : mflags[wr_slot];
        setv = 0; clrv = 0;
        merr = wr_en && blk;
        if (wr_en && !blk) begin
            a = int'(wr_slot) * 16 + int'(wr_word);
            mmem[a] = wr_data; mvalid[a] = 1;
            if (wr_word == 4'd15) setv[wr_slot] = 1;
        end
        if (ack_en) clrv[ack_slot] = 1;
        mflags = (mflags & ~clrv) | setv;
        if (mask_wr_en) mmask = mask_wr_data;
        @(negedge clk);
        check(full_flags == mflags, cur_req, "full_flags", 32'(full_flags), 32'(mflags));
        check(irq == |(mflags & ~mmask), (cur_req == "R1") ? "R1" : "R8", "irq",
              32'(irq), 32'(|(mflags & ~mmask)));
        check(wr_err == merr, merr ? "R4" : "R10", "wr_err", 32'(wr_err), 32'(merr));
        a = int'(rd_slot) * 16 + int'(rd_word);
        if (mvalid[a]) check(rd_data == mmem[a], cur_req, "rd_data", rd_data, mmem[a]);
        idle();
    endtask

    task automatic wr(input int s, input int w, input logic [31:0] d);
        wr_en = 1; wr_slot = 3'(s); wr_word = 4'(w); wr_data = d;
        rd_slot = 3'(s); rd_word = 4'(w);
        tick();
    endtask

    task automatic fill(input int s, input int base);
        for (int w = 0; w < 16; w++) wr(s, w, 32'(base + w * 7));
    endtask

    task automatic ack(input int s);
        ack_en = 1; ack_slot = 3'(s);
        tick();
    endtask

    task automatic rd(input int s, input int w);
        rd_slot = 3'(s); rd_word = 4'(w);
        tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 128; i++) mvalid[i] = 0;
        idle(); rd_slot = 0; rd_word = 0; strict_mode = 0; rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        // R1 reset state
        check(full_flags == 8'h00, "R1", "flags after reset", 32'(full_flags), 0);
        check(irq == 1'b0, "R1", "irq after reset", 32'(irq), 0);
        check(wr_err == 1'b0, "R1", "wr_err after reset", 32'(wr_err), 0);
        tick();

        // R2 / R3: fill slot 2, read back
        cur_req = "R2";
        for (int w = 0; w < 15; w++) wr(2, w, 32'hA000 + 32'(w));
        cur_req = "R3";
        wr(2, 15, 32'hA0FF);
        check(full_flags[2] == 1'b1, "R3", "slot2 flag after last word", 32'(full_flags), 32'h4);
        cur_req = "R2";
        rd(2, 0); rd(2, 9); rd(2, 15);

        // R4: rewrite a full slot
        cur_req = "R4";
        wr(2, 3, 32'hDEAD_BEEF);
        rd(2, 3);
        check(rd_data == 32'hA003, "R4", "rejected write left data", rd_data, 32'hA003);
        wr(2, 15, 32'h1234);

        // R5: several full slots, out-of-order service
        cur_req = "R5";
        fill(5, 32'h5000); fill(0, 32'h0100); fill(7, 32'h7700);
        check(full_flags == 8'hA5, "R5", "four slots full", 32'(full_flags), 32'hA5);
        rd(7, 4); rd(0, 11); rd(2, 15); rd(5, 1);
        cur_req = "R6";
        ack(7); ack(0);
        check(full_flags == 8'h24, "R6", "after acking 7 then 0", 32'(full_flags), 32'h24);
        ack(0);
        check(full_flags == 8'h24, "R6", "ack of clear slot", 32'(full_flags), 32'h24);
        ack(2);

        // R7: set and clear same edge
        cur_req = "R7";
        for (int w = 0; w < 15; w++) wr(4, w, 32'h4400 + 32'(w));
        wr_en = 1; wr_slot = 3'd4; wr_word = 4'd15; wr_data = 32'h44FF;
        ack_en = 1; ack_slot = 3'd4;
        tick();
        check(full_flags[4] == 1'b1, "R7", "set wins over ack", 32'(full_flags), 32'h30);

        // R8: masking
        cur_req = "R8";
        mask_wr_en = 1; mask_wr_data = 8'h30; tick();
        check(irq == 1'b0, "R8", "all full slots masked", 32'(irq), 0);
        mask_wr_en = 1; mask_wr_data = 8'h10; tick();
        check(irq == 1'b1, "R8", "slot5 unmasked", 32'(irq), 1);
        ack(5);
        check(irq == 1'b0, "R8", "only masked slot4 full", 32'(irq), 0);
        mask_wr_en = 1; mask_wr_data = 8'h00; tick();
        ack(4); tick();

        // R9: strict handshake
        cur_req = "R9";
        strict_mode = 1;
        fill(1, 32'h1100);
        wr(3, 0, 32'h3300);
        check(wr_err == 1'b1, "R9", "strict refuses other slot", 32'(wr_err), 1);
        ack(1);
        wr(3, 0, 32'h3301);
        check(wr_err == 1'b0, "R9", "strict accepts after ack", 32'(wr_err), 0);
        rd(3, 0);
        check(rd_data == 32'h3301, "R9", "strict write stored", rd_data, 32'h3301);
        strict_mode = 0;

        // R10 idle
        cur_req = "R10";
        repeat (4) tick();
        check(wr_err == 1'b0, "R10", "idle wr_err", 32'(wr_err), 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule